// File: doc/BRIEF.md
# Single-Master I2C Bus Controller

This block drives an I2C bus as its only master, under the control of a CPU through three byte-wide registers: status, control and data. Software places a slave address byte in the data register. It then sets the master and start bits in the control register. The controller waits for bus-free time, puts a START condition on the bus and shifts the address out MSB first. It then samples the acknowledge on the ninth clock, raises a byte-complete flag and holds SCL low until software asks for the next byte.

For each later byte, software clears the byte-complete flag. In transmit direction the engine sends the data register contents. In receive direction it shifts a byte from the slave into the data register, and drives the ninth-clock acknowledge when acknowledge is enabled. Clearing the master bit while the engine is holding the bus produces a STOP. The bus-busy flag drops once the STOP is on the wire.

SCL and SDA are open drain. The block only asserts active-high pull-low enables and reads the SDA line back. SCL runs at the system clock divided by four times a quarter-period parameter.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset, status (offset 0xC9) reads 0x08, control (offset 0xCA) reads 0x00, data (offset 0xCB) reads 0x00, both pull-low outputs are 0 and irq is 0.
- R2: A control write with start (bit 5) = 1 and master (bit 4) = 1 is accepted only while the bus is not busy and no start is pending. After acceptance, start reads 1 until the START condition has been put on the bus, and reads 0 from the point busy reads 1. Every other write of start has no effect, including a rewrite of 1 during a pending start.
- R3: Status bit 7 (busy) becomes 1 once START is on the bus. It returns to 0 after the STOP that follows clearing the master bit while the engine holds the bus.
- R4: A data write while busy is 0 sets status bit 3 to the inverse of the written LSB (LSB 0 gives 1 = transmit, LSB 1 gives 0 = receive). Data writes while busy is 1 leave bit 3 unchanged.
- R5: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. With busy 0 and no start pending, both lines are released.
- R6: Within a byte, SDA changes only while SCL is low, so each transaction has exactly two SDA edges while SCL is high.
- R7: Status bit 4 holds the SDA level sampled on the ninth SCL high of the latest byte (0 = acknowledged). It is updated for every byte, address bytes included.
- R8: Each completed byte sets control bit 0 (byte-complete flag). Writing 0 there clears it, writing 1 has no effect, and a completing byte wins over a clearing write in the same cycle. irq is 1 exactly when that flag and control bit 1 are both 1.
- R9: Clearing the byte-complete flag with master still 1 starts the next byte. The first byte after START is always sent. Later bytes are sent from the data register when status bit 3 is 1, or received into it when bit 3 is 0. In a received byte the master pulls SDA low on the ninth clock only if control bit 3 is 1.
- R10: SCL high time in a byte is 2*QTR_DIV system clocks.
- R11: Reads of any offset other than the three registers return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sda_in | input | 1 | Level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle. The hardware clears the start bit when START completes, and software may write the control register with start still 1 because it rewrites the value it read back. The bench provokes this by writing that value on every clock from the start request until SCL first falls after START. It then requires that start reads 0, that busy reads 1, and that only two SDA edges with SCL high occur in the whole transaction. The same collision exists between a completing byte setting the flag and a clearing write; the flag's set priority guards it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {
      EN_IDLE,
      EN_START,
      EN_BIT,
      EN_WAIT,
      EN_STOP
   } eng_state_t;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned ACK_SLOT   = 8;
   // control register bit positions
   localparam int unsigned CB_START   = 5;
   localparam int unsigned CB_MASTER  = 4;
   localparam int unsigned CB_ACKEN   = 3;
   localparam int unsigned CB_IRQEN   = 1;
   localparam int unsigned CB_DONE    = 0;
   // status register bit positions
   localparam int unsigned SB_BUSY    = 7;
   localparam int unsigned SB_ACK     = 4;
   localparam int unsigned SB_TX      = 3;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int unsigned QTR_DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (QTR_DIV == 1) begin : g_every
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned CW = $clog2(QTR_DIV);
         localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_req,
   input  logic              master_on,
   input  logic              ack_en,
   input  logic              done_flag,
   input  logic              dir_tx,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              sda_in,
   output logic              scl_lo,
   output logic              sda_lo,
   output logic              start_done,
   output logic              stop_done,
   output logic              byte_done,
   output logic              ack_bit,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte
);
   eng_state_t        st;
   logic [1:0]        q;
   logic [3:0]        bitn;
   logic [BYTE_W-1:0] shreg;
   logic              first;
   logic              byte_tx;
   logic              drive;

   assign byte_tx = first | dir_tx;
   assign drive   = (bitn < 4'(ACK_SLOT)) ? (byte_tx & ~shreg[BYTE_W-1])
                                          : (~byte_tx & ack_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= EN_IDLE;  q <= '0;  bitn <= '0;  shreg <= '0;  first <= 1'b0;
         scl_lo <= 1'b0; sda_lo <= 1'b0;
         start_done <= 1'b0; stop_done <= 1'b0; byte_done <= 1'b0;
         rx_valid <= 1'b0;   ack_bit <= 1'b0;   rx_byte <= '0;
      end else begin
         start_done <= 1'b0; stop_done <= 1'b0; byte_done <= 1'b0; rx_valid <= 1'b0;
         if (tick) begin
            unique case (st)
               EN_IDLE: begin
                  scl_lo <= 1'b0; sda_lo <= 1'b0; q <= '0;
                  if (start_req && master_on) st <= EN_START;
               end
               EN_START: begin
                  q <= q + 2'd1;
                  if (q == 2'd2) sda_lo <= 1'b1;
                  if (q == 2'd3) begin
                     start_done <= 1'b1;
                     st    <= EN_BIT;
                     bitn  <= '0;
                     shreg <= tx_data;
                     first <= 1'b1;
                  end
               end
               EN_BIT: begin
                  q <= q + 2'd1;
                  case (q)
                     2'd0: scl_lo <= 1'b1;
                     2'd1: sda_lo <= drive;
                     2'd2: scl_lo <= 1'b0;
                     default: begin
                        if (bitn == 4'(ACK_SLOT)) begin
                           ack_bit   <= sda_in;
                           byte_done <= 1'b1;
                           rx_valid  <= ~byte_tx;
                           rx_byte   <= shreg;
                           first     <= 1'b0;
                           st        <= EN_WAIT;
                        end else begin
                           shreg <= {shreg[BYTE_W-2:0], sda_in};
                           bitn  <= bitn + 4'd1;
                        end
                     end
                  endcase
               end
               EN_WAIT: begin
                  scl_lo <= 1'b1;
                  if (q == 2'd0) begin
                     q <= 2'd1;
                  end else if (!master_on) begin
                     q <= '0; st <= EN_STOP;
                  end else if (!done_flag) begin
                     q <= '0; st <= EN_BIT; bitn <= '0; shreg <= tx_data;
                  end
               end
               EN_STOP: begin
                  q <= q + 2'd1;
                  case (q)
                     2'd0: sda_lo <= 1'b1;
                     2'd1: scl_lo <= 1'b0;
                     2'd2: sda_lo <= 1'b0;
                     default: begin
                        stop_done <= 1'b1;
                        st <= EN_IDLE;
                     end
                  endcase
               end
               default: st <= EN_IDLE;
            endcase
         end
      end
   end

   // R6: within a byte SDA must hold while SCL stays released
   p_sda_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == EN_BIT && !scl_lo && $past(!scl_lo)) |-> $stable(sda_lo))
      else $error("SDA moved while SCL high inside a byte");
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
   import i2cm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned STAT_OFS = 'hC9,
   parameter int unsigned CTRL_OFS = 'hCA,
   parameter int unsigned DATA_OFS = 'hCB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              start_done,
   input  logic              stop_done,
   input  logic              byte_done,
   input  logic              ack_bit,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              start_req,
   output logic              master_on,
   output logic              ack_en,
   output logic              irq_en,
   output logic              done_flag,
   output logic              dir_tx,
   output logic [BYTE_W-1:0] tx_data,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);

   logic wr_ctrl, wr_data, last_ack;
   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[2]};

   assign wr_ctrl = reg_sel & reg_wr & (reg_addr == A_CTRL);
   assign wr_data = reg_sel & reg_wr & (reg_addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_req <= 1'b0; master_on <= 1'b0; ack_en <= 1'b0; irq_en <= 1'b0;
         done_flag <= 1'b0; busy <= 1'b0; last_ack <= 1'b0; dir_tx <= 1'b1;
         tx_data <= '0;
      end else begin
         if (start_done)
            start_req <= 1'b0;
         else if (wr_ctrl && reg_wdata[CB_START] && reg_wdata[CB_MASTER] && !start_req && !busy)
            start_req <= 1'b1;
         if (wr_ctrl) begin
            master_on <= reg_wdata[CB_MASTER];
            ack_en    <= reg_wdata[CB_ACKEN];
            irq_en    <= reg_wdata[CB_IRQEN];
         end
         if (byte_done)                          done_flag <= 1'b1;
         else if (wr_ctrl && !reg_wdata[CB_DONE]) done_flag <= 1'b0;
         if (start_done)     busy <= 1'b1;
         else if (stop_done) busy <= 1'b0;
         if (byte_done) last_ack <= ack_bit;
         if (wr_data && !busy) dir_tx <= ~reg_wdata[0];
         if (rx_valid)     tx_data <= rx_byte;
         else if (wr_data) tx_data <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STAT) begin
         reg_rdata[SB_BUSY] = busy;
         reg_rdata[SB_ACK]  = last_ack;
         reg_rdata[SB_TX]   = dir_tx;
      end else if (reg_addr == A_CTRL) begin
         reg_rdata[CB_START]  = start_req;
         reg_rdata[CB_MASTER] = master_on;
         reg_rdata[CB_ACKEN]  = ack_en;
         reg_rdata[CB_IRQEN]  = irq_en;
         reg_rdata[CB_DONE]   = done_flag;
      end else if (reg_addr == A_DATA) begin
         reg_rdata = tx_data;
      end
   end

   // R2: a start request can only be armed while the bus is free
   p_start_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_req) |-> $past(!busy))
      else $error("start armed while busy");
   // R8: a completed byte always leaves the flag set
   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> done_flag)
      else $error("byte completion lost");
   // R4: direction frozen while the bus stays busy
   p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(dir_tx))
      else $error("direction changed during transfer");
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
   import i2cm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned QTR_DIV  = 125,
   parameter int unsigned STAT_OFS = 'hC9,
   parameter int unsigned CTRL_OFS = 'hCA,
   parameter int unsigned DATA_OFS = 'hCB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              sda_in,
   output logic              scl_pull,
   output logic              sda_pull,
   output logic              irq
);
   initial begin
      assert (QTR_DIV >= 1) else $error("QTR_DIV must be at least 1");
      assert (ADDR_W >= 1 && ADDR_W <= 31) else $error("ADDR_W out of range");
      assert (STAT_OFS != CTRL_OFS && STAT_OFS != DATA_OFS && CTRL_OFS != DATA_OFS)
         else $error("register offsets overlap");
      assert (STAT_OFS < (1 << ADDR_W) && CTRL_OFS < (1 << ADDR_W) && DATA_OFS < (1 << ADDR_W))
         else $error("register offset outside window");
   end

   logic tick, start_req, master_on, ack_en, irq_en, done_flag, dir_tx, busy;
   logic start_done, stop_done, byte_done, ack_bit, rx_valid;
   logic [BYTE_W-1:0] tx_data, rx_byte;

   i2cm_tick #(.QTR_DIV(QTR_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   i2cm_regs #(
      .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .start_done(start_done), .stop_done(stop_done), .byte_done(byte_done),
      .ack_bit(ack_bit), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .start_req(start_req), .master_on(master_on), .ack_en(ack_en),
      .irq_en(irq_en), .done_flag(done_flag), .dir_tx(dir_tx),
      .tx_data(tx_data), .busy(busy)
   );

   i2cm_engine u_engine (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
      .master_on(master_on), .ack_en(ack_en), .done_flag(done_flag),
      .dir_tx(dir_tx), .tx_data(tx_data), .sda_in(sda_in),
      .scl_lo(scl_pull), .sda_lo(sda_pull), .start_done(start_done),
      .stop_done(stop_done), .byte_done(byte_done), .ack_bit(ack_bit),
      .rx_valid(rx_valid), .rx_byte(rx_byte)
   );

   assign irq = done_flag & irq_en;

   // R5: bus fully released whenever nothing is owned or pending
   p_lines_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_req) |-> (!scl_pull && !sda_pull))
      else $error("lines driven while bus idle");
   // R3: busy only rises after a start request was pending
   p_busy_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_req))
      else $error("busy without start request");
endmodule

// File: tb/i2c_host_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_host_ctrl_tb;
   localparam int unsigned QTR = 4;
   localparam logic [7:0] A_ST = 8'hC9, A_CT = 8'hCA, A_DA = 8'hCB;
   localparam logic [6:0] SLV = 7'h2A;
   localparam logic [7:0] SLV_TX = 8'hA5;
   // {byte written to data while idle, expected status}
   localparam logic [15:0] DIR_VEC [0:3] = '{16'h5408, 16'h5500, 16'hFF00, 16'hA008};

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_sel = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic scl_pull, sda_pull, irq;
   logic scl_line, sda_line;
   logic slv_lo = 1'b0;
   int n_chk = 0, n_fail = 0, hi_edges = 0;

   always #2.5 clk = ~clk;

   assign scl_line = ~scl_pull;
   assign sda_line = ~(sda_pull | slv_lo);

   i2c_host_ctrl #(.QTR_DIV(QTR)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull), .irq(irq)
   );

   // simple slave model
   logic slv_act = 1'b0, slv_rd = 1'b0, slv_match = 1'b0, slv_mnack = 1'b0;
   logic [7:0] slv_sh = '0, slv_got = '0;
   int slv_bit = 0, slv_idx = 0;

   always @(negedge sda_line) if (rst_n === 1'b1 && scl_line === 1'b1) begin
      slv_act = 1'b1; slv_bit = 0; slv_idx = 0; slv_lo = 1'b0; slv_mnack = 1'b0;
   end
   always @(posedge sda_line) if (rst_n === 1'b1 && scl_line === 1'b1) begin
      slv_act = 1'b0; slv_lo = 1'b0;
   end
   always @(posedge scl_line) if (slv_act) begin
      if (slv_bit < 8) slv_sh = {slv_sh[6:0], sda_line};
      else if (slv_rd && slv_idx > 0) slv_mnack = sda_line;
      slv_bit++;
   end
   always @(negedge scl_line) if (slv_act) begin
      if (slv_bit == 8) begin
         if (slv_idx == 0) begin
            slv_match = (slv_sh[7:1] == SLV); slv_rd = slv_sh[0]; slv_lo = slv_match;
         end else if (!slv_rd) begin
            slv_got = slv_sh; slv_lo = slv_match;
         end else slv_lo = 1'b0;
      end else if (slv_bit == 9) begin
         slv_bit = 0; slv_idx++;
         slv_lo = slv_match && slv_rd && !slv_mnack && !SLV_TX[7];
      end else if (slv_match && slv_rd && slv_idx > 0 && !slv_mnack)
         slv_lo = !SLV_TX[7 - slv_bit];
   end

   always @(sda_line) if (rst_n === 1'b1 && scl_line === 1'b1) hi_edges++;

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_done();
      logic [7:0] v;
      for (int i = 0; i < 4000; i++) begin
         rd(A_CT, v);
         if (v[0]) break;
      end
   endtask

   task automatic wait_free();
      logic [7:0] v;
      for (int i = 0; i < 4000; i++) begin
         rd(A_ST, v);
         if (!v[7]) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n;
      logic saw_low;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(A_ST, v); chk("R1 status", v, 8'h08);
      rd(A_CT, v); chk("R1 control", v, 8'h00);
      rd(A_DA, v); chk("R1 data", v, 8'h00);
      chk("R1 lines/irq", {5'b0, scl_pull, sda_pull, irq}, 8'h00);
      rd(8'h00, v); chk("R11 unmapped", v, 8'h00);
      // R4 direction table while idle
      for (int i = 0; i < 4; i++) begin
         wr(A_DA, DIR_VEC[i][15:8]);
         rd(A_ST, v); chk("R4 dir table", v, DIR_VEC[i][7:0]);
      end
      // R8 writing 1 to the flag has no effect
      wr(A_CT, 8'h01); rd(A_CT, v); chk("R8 set by write ignored", v, 8'h00);
      // R2 start without master ignored
      wr(A_CT, 8'h20); rd(A_CT, v); chk("R2 start w/o master", v, 8'h00);
      repeat (40) @(negedge clk);
      rd(A_ST, v); chk("R2 no busy", v, 8'h08);

      // write transaction
      wr(A_DA, 8'h54);
      wr(A_CT, 8'h32);
      rd(A_CT, v); chk("R2 start pending", v, 8'h32);
      saw_low = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = A_CT; reg_wdata = 8'h32;
         if (sda_line == 1'b0) saw_low = 1'b1;
         if (saw_low && scl_line == 1'b0) break;
      end
      @(negedge clk); reg_wr = 1'b0;
      rd(A_CT, v); chk("R2 start self-clear", v, 8'h12);
      rd(A_ST, v); chk("R3 busy after START", v, 8'h88);
      wait_done();
      rd(A_ST, v); chk("R7 address acked", v, 8'h88);
      chk("R8 irq pin", {7'b0, irq}, 8'h01);
      wr(A_DA, 8'h3D);
      rd(A_ST, v); chk("R4 dir held while busy", v, 8'h88);
      wr(A_CT, 8'h13);
      rd(A_CT, v); chk("R8 write 1 keeps flag", v, 8'h13);
      wr(A_CT, 8'h12);
      @(posedge scl_line);
      n = 0;
      while (scl_line) begin
         @(negedge clk);
         if (scl_line) n++;
      end
      chk("R10 SCL high time", 8'(n), 8'(2 * QTR));
      wait_done();
      chk("R9 slave got byte", slv_got, 8'h3D);
      rd(A_ST, v); chk("R7 data acked", v, 8'h88);
      wr(A_CT, 8'h02);
      wait_free();
      rd(A_ST, v); chk("R3 busy drops after STOP", v, 8'h08);
      chk("R5 lines released", {6'b0, scl_pull, sda_pull}, 8'h00);
      chk("R8 irq low after clear", {7'b0, irq}, 8'h00);

      // read transaction
      wr(A_DA, 8'h55);
      rd(A_ST, v); chk("R4 read dir", v, 8'h00);
      wr(A_CT, 8'h3A);
      wait_done();
      rd(A_ST, v); chk("R7 read address acked", v, 8'h80);
      wr(A_CT, 8'h1A);
      wait_done();
      rd(A_DA, v); chk("R9 rx byte acked", v, SLV_TX);
      rd(A_ST, v); chk("R9 master ack sampled", v, 8'h80);
      wr(A_CT, 8'h12);
      wait_done();
      rd(A_DA, v); chk("R9 rx byte nacked", v, SLV_TX);
      rd(A_ST, v); chk("R9 master nack sampled", v, 8'h90);
      wr(A_CT, 8'h02);
      wait_free();
      rd(A_ST, v); chk("R3 read stop", v, 8'h10);

      // unmatched address, interrupt disabled
      wr(A_DA, 8'h40);
      rd(A_ST, v); chk("R4 dir reload", v, 8'h18);
      wr(A_CT, 8'h30);
      wait_done();
      rd(A_ST, v); chk("R7 address nack", v, 8'h98);
      rd(A_CT, v); chk("R8 flag without enable", v, 8'h11);
      chk("R8 irq masked", {7'b0, irq}, 8'h00);
      wr(A_CT, 8'h00);
      wait_free();
      rd(A_ST, v); chk("R3 final idle", v, 8'h18);
      chk("R6 SDA edges with SCL high", 8'(hi_edges), 8'd6);

      summary();
      $finish;
   end
endmodule